// File: doc/BRIEF.md
# Fractional-N Three-Modulus Divider Sequencer

This block sits behind an external 64/65/72 prescaler and is clocked by the prescaler's output pulses. Each of those clocks is one sub-cycle. For every sub-cycle the block drives a modulus code that tells the prescaler which ratio to use next. One main-divider cycle is built from three phases in a fixed order: a 65 phase, then a 72 phase (three-modulus mode only), then a 64 phase. The last sub-cycle of the 64 phase raises a one-clock divider pulse, which feeds the phase comparator.

At every cycle end a 3-bit fractional accumulator adds the increment. The addition is modulo 8 or modulo 5. When the addition wraps, the following cycle uses one more 65 sub-cycle and one fewer 64 sub-cycle, so the average division ratio is N + nf/Q. The accumulator value is exported so that ripple compensation can use it.

The configuration inputs are sampled only at the edge that closes a cycle. A load-permit output is high during the 64 phase, which is the window in which software may safely change the settings.

The controller is a three-state machine. Its states are `PH_M65`, `PH_M72` and `PH_M64`, and each state holds a down-counter. The transitions are:

- Restart, on reset or cycle end. The machine enters the first non-empty phase: `PH_M65`, else `PH_M72`, else `PH_M64`.
- Phase advance, when the counter reaches zero:
  - `PH_M65` goes to `PH_M72` if that phase is non-empty, and otherwise to `PH_M64`.
  - `PH_M72` goes to `PH_M64`.
- Count, in every other cycle. The machine stays in its state and decrements the counter.

Top module: `mmd_frac_ctrl`

## Requirements
- R1: `mod_sel` codes the modulus as 0 for 64, 1 for 65 and 2 for 72. Within a cycle the 65 sub-cycles come first, then the 72 sub-cycles, then the 64 sub-cycles.
- R2: With `pr_cfg[1]`=0 (two-modulus, e.g. 2'b01), a cycle without overflow has `nm2_cfg` (8 bits) sub-cycles at 65, followed by `nm1_cfg`+2 sub-cycles at 64. It has no 72 sub-cycles.
- R3: With `pr_cfg[1]`=1 (three-modulus, 2'b10), a cycle without overflow has `nm2_cfg[3:0]` sub-cycles at 65, then `nm3_cfg`+1 at 72, then `nm1_cfg`+2 at 64. Bits `nm2_cfg[7:4]` are ignored in this mode.
- R4: `div_pulse` is high during the final sub-cycle of each cycle, and only then. It is one clock wide.
- R5: At the edge that closes a cycle, `acc_out` becomes (acc + nf) mod Q. Q is 8 when `fmod_cfg`=1 and 5 when it is 0. The nf and Q used are those in force for the cycle that is closing. `acc_out` holds at every other edge. nf values at or above Q are outside the supported range.
- R6: When that addition reaches or exceeds Q, the next cycle has one extra 65 sub-cycle and one fewer 64 sub-cycle.
- R7: `load_ok` is high exactly during the 64 phase. Configuration inputs are sampled only at the cycle-closing edge, so a change at any other time has no effect on the cycle in progress.
- R8: A synchronous reset clears the accumulator and any pending overflow. It then starts a fresh cycle from the current inputs.
- R9: Over any Q consecutive cycles with constant settings, the summed moduli equal Q·N + nf. N is the integer ratio given by R2 or R3.
- R10: When the 65 phase has zero length, it is skipped entirely and the cycle begins in the next phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output pulse clock |
| rst | input | 1 | Synchronous reset, active high |
| nm1_cfg | input | 12 | Count setting for the 64 phase |
| nm2_cfg | input | 8 | Count setting for the 65 phase (low 4 bits in three-modulus mode) |
| nm3_cfg | input | 4 | Count setting for the 72 phase |
| pr_cfg | input | 2 | Prescaler mode; bit 1 selects three-modulus |
| nf_cfg | input | 3 | Fractional increment |
| fmod_cfg | input | 1 | Accumulator modulus: 1 gives 8, 0 gives 5 |
| mod_sel | output | 2 | Modulus code for the current sub-cycle |
| div_pulse | output | 1 | Main divider output pulse |
| acc_out | output | 3 | Fractional accumulator contents |
| load_ok | output | 1 | Safe-reprogramming window |

## Verification
Three events can fall in the same cycle: the cycle-closing edge, the accumulator wrap, and the capture of new settings. At that single edge the wrap decides the next cycle's phase lengths, while the freshly captured settings decide its base. The bench provokes this coincidence by changing `nm1_cfg` and `nm2_cfg` in the middle of a 65 phase while nf is nonzero. It also runs a case with `nm1_cfg`=0 and `nm2_cfg`=0, where a wrap turns an empty 65 phase into a one-sub-cycle phase and shrinks the 64 phase to a single sub-cycle. Its behavioural model rebuilds the expected modulus sequence at each cycle end, and the outputs are compared against that sequence on every clock.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
    typedef enum logic [1:0] {
        PH_M64 = 2'd0,
        PH_M65 = 2'd1,
        PH_M72 = 2'd2
    } phase_e;
endpackage

// File: rtl/mmd_frac_acc.sv
module mmd_frac_acc #(
    parameter int ACC_W = 3,
    parameter int Q_HI  = 8,
    parameter int Q_LO  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [ACC_W-1:0] inc,
    input  logic             fmod,
    output logic [ACC_W-1:0] acc_q,
    output logic             carry
);
    localparam int SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] qmod;
    logic [SUM_W-1:0] wrapped;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, inc};
        qmod    = fmod ? SUM_W'(Q_HI) : SUM_W'(Q_LO);
        carry   = (sum >= qmod);
        wrapped = carry ? (sum - qmod) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (step)
            acc_q <= wrapped[ACC_W-1:0];
    end

    // R5: value moves only at a cycle-closing edge
    a_r5_acc_holds: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(acc_q));
    // R8: reset leaves an empty accumulator
    a_r8_acc_cleared: assert property (@(posedge clk)
        rst |=> (acc_q == '0));
endmodule

// File: rtl/mmd_phase_seq.sv
module mmd_phase_seq
    import mmd_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] ent_len65,
    input  logic [CNT_W-1:0] ent_len72,
    input  logic [CNT_W-1:0] ent_len64,
    output logic [1:0]       mod_sel,
    output logic             cycle_end,
    output logic             load_ok
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len72_q, len64_q;

    // output process
    always_comb begin
        mod_sel   = 2'd0;
        cycle_end = 1'b0;
        load_ok   = 1'b0;
        unique case (state_q)
            PH_M65: mod_sel = 2'd1;
            PH_M72: mod_sel = 2'd2;
            PH_M64: begin
                mod_sel   = 2'd0;
                load_ok   = 1'b1;
                cycle_end = (cnt_q == '0);
            end
            default: mod_sel = 2'd0;
        endcase
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rst || cycle_end) begin
            if (ent_len65 != '0) begin
                state_d = PH_M65;
                cnt_d   = ent_len65 - ONE;
            end else if (ent_len72 != '0) begin
                state_d = PH_M72;
                cnt_d   = ent_len72 - ONE;
            end else begin
                state_d = PH_M64;
                cnt_d   = ent_len64 - ONE;
            end
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end else begin
            unique case (state_q)
                PH_M65: begin
                    if (len72_q != '0) begin
                        state_d = PH_M72;
                        cnt_d   = len72_q - ONE;
                    end else begin
                        state_d = PH_M64;
                        cnt_d   = len64_q - ONE;
                    end
                end
                PH_M72: begin
                    state_d = PH_M64;
                    cnt_d   = len64_q - ONE;
                end
                default: begin
                    state_d = state_q;
                    cnt_d   = cnt_q;
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
        if (rst || cycle_end) begin
            len72_q <= ent_len72;
            len64_q <= ent_len64;
        end
    end

    // R1: phase order 65 -> 72 -> 64
    a_r1_leave65: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_M65 && state_d != PH_M65) |=> (state_q != PH_M65));
    a_r1_after72: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_M72 && !cycle_end) |=> (state_q == PH_M72 || state_q == PH_M64));
    // R4: divider pulse is a single clock wide
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> !cycle_end);
endmodule

// File: rtl/mmd_frac_ctrl.sv
module mmd_frac_ctrl
    import mmd_pkg::*;
#(
    parameter int NM1_W = 12,
    parameter int NM2_W = 8,
    parameter int NM3_W = 4,
    parameter int NF_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NM1_W-1:0] nm1_cfg,
    input  logic [NM2_W-1:0] nm2_cfg,
    input  logic [NM3_W-1:0] nm3_cfg,
    input  logic [1:0]       pr_cfg,
    input  logic [NF_W-1:0]  nf_cfg,
    input  logic             fmod_cfg,
    output logic [1:0]       mod_sel,
    output logic             div_pulse,
    output logic [NF_W-1:0]  acc_out,
    output logic             load_ok
);
    localparam int CNT_W = NM1_W + 1;

    logic             cycle_end;
    logic             carry;
    logic             ovf;
    logic [NF_W-1:0]  w_nf;
    logic             w_fmod;
    logic [CNT_W-1:0] n2_eff, len65, len72, len64;

    // working copies of the fractional settings for the running cycle
    always_ff @(posedge clk) begin
        if (rst || cycle_end) begin
            w_nf   <= nf_cfg;
            w_fmod <= fmod_cfg;
        end
    end

    always_comb begin
        ovf    = !rst && carry;
        n2_eff = pr_cfg[1] ? CNT_W'(nm2_cfg[NM3_W-1:0]) : CNT_W'(nm2_cfg);
        len65  = n2_eff + CNT_W'(ovf);
        len72  = pr_cfg[1] ? (CNT_W'(nm3_cfg) + CNT_W'(1)) : '0;
        len64  = CNT_W'(nm1_cfg) + CNT_W'(2) - CNT_W'(ovf);
    end

    mmd_frac_acc #(.ACC_W(NF_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (cycle_end),
        .inc   (w_nf),
        .fmod  (w_fmod),
        .acc_q (acc_out),
        .carry (carry)
    );

    mmd_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ent_len65 (len65),
        .ent_len72 (len72),
        .ent_len64 (len64),
        .mod_sel   (mod_sel),
        .cycle_end (cycle_end),
        .load_ok   (load_ok)
    );

    assign div_pulse = cycle_end;

    // R7: the reprogramming window closes with the divider pulse
    a_r7_window_closes: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> (load_ok == (mod_sel == 2'd0)));
    // R6: a wrap in three-modulus mode with an empty 65 setting still opens a 65 phase
    a_r6_wrap_adds65: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && carry && pr_cfg[1] && nm2_cfg[NM3_W-1:0] == '0) |=> (mod_sel == 2'd1));
endmodule

// File: tb/test_mmd_frac_ctrl.sv
module test_mmd_frac_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] nm1 = 12'd3;
    logic [7:0]  nm2 = 8'd2;
    logic [3:0]  nm3 = 4'd0;
    logic [1:0]  pr  = 2'b01;
    logic [2:0]  nf  = 3'd0;
    logic        fmod = 1'b1;
    logic [1:0]  mod_sel;
    logic        div_pulse;
    logic [2:0]  acc_out;
    logic        load_ok;

    always #5 clk = ~clk;

    mmd_frac_ctrl i_mmd_frac_ctrl (
        .clk(clk), .rst(rst), .nm1_cfg(nm1), .nm2_cfg(nm2), .nm3_cfg(nm3),
        .pr_cfg(pr), .nf_cfg(nf), .fmod_cfg(fmod), .mod_sel(mod_sel),
        .div_pulse(div_pulse), .acc_out(acc_out), .load_ok(load_ok)
    );

    int checks = 0;
    int fails  = 0;
    int q[$];
    int m_acc = 0;
    int m_wnf = 0;
    int m_wfmod = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input int m);
        return (m == 64) ? 0 : ((m == 65) ? 1 : 2);
    endfunction

    function automatic int modulus_of(input logic [1:0] c);
        return (c == 2'd0) ? 64 : ((c == 2'd1) ? 65 : 72);
    endfunction

    function automatic void build(input int ov);
        int n2;
        q.delete();
        n2 = pr[1] ? int'(nm2[3:0]) : int'(nm2);
        for (int i = 0; i < n2 + ov; i++) q.push_back(65);
        if (pr[1]) for (int i = 0; i < int'(nm3) + 1; i++) q.push_back(72);
        for (int i = 0; i < int'(nm1) + 2 - ov; i++) q.push_back(64);
    endfunction

    // behavioural reference, compared every clock
    always @(negedge clk) begin
        if (rst) begin
            m_acc = 0;
            m_wnf = int'(nf);
            m_wfmod = int'(fmod);
            build(0);
        end else begin
            chk(int'(mod_sel) == code_of(q[0]), "R1/R2/R3 mod_sel", int'(mod_sel), code_of(q[0]));
            chk(div_pulse == (q.size() == 1), "R4 div_pulse", int'(div_pulse), int'(q.size() == 1));
            chk(load_ok == (q[0] == 64), "R7 load_ok", int'(load_ok), int'(q[0] == 64));
            chk(int'(acc_out) == m_acc, "R5 acc_out", int'(acc_out), m_acc);
            void'(q.pop_front());
            if (q.size() == 0) begin
                int s, qm, ov;
                s  = m_acc + m_wnf;
                qm = m_wfmod ? 8 : 5;
                ov = (s >= qm) ? 1 : 0;
                m_acc = ov ? s - qm : s;
                m_wnf = int'(nf);
                m_wfmod = int'(fmod);
                build(ov);
            end
        end
    end

    task automatic setcfg(input int p, input int n1, input int n2, input int n3,
                          input int f, input int fm);
        @(posedge clk); #1;
        pr = 2'(p); nm1 = 12'(n1); nm2 = 8'(n2); nm3 = 4'(n3);
        nf = 3'(f); fmod = 1'(fm);
    endtask

    task automatic wait_pulses(input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk); #1;
            if (div_pulse) seen++;
        end
    endtask

    // sums moduli over n whole cycles, starting right after a pulse
    task automatic measure(input int n, input int expv, input string req);
        int vsum = 0;
        int seen = 0;
        wait_pulses(1);
        while (seen < n) begin
            @(negedge clk); #1;
            vsum += modulus_of(mod_sel);
            if (div_pulse) seen++;
        end
        chk(vsum == expv, req, vsum, expv);
    endtask

    task automatic run_tests();
        // R8: reset state
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        chk(acc_out == 3'd0, "R8 acc after reset", int'(acc_out), 0);
        chk(mod_sel == 2'd1, "R8 first phase is 65", int'(mod_sel), 1);
        wait_pulses(3);

        // R9: two-modulus, Q=8, nf=3, N=5*64+2*65=450
        setcfg(2'b01, 3, 2, 0, 3, 1);
        wait_pulses(2);
        measure(8, 8 * 450 + 3, "R9 two-modulus Q=8");

        // R3 and R9: three-modulus, upper nm2 bits ignored, N=4*64+3*65+2*72=595
        setcfg(2'b10, 2, 8'hA3, 1, 2, 0);
        wait_pulses(2);
        measure(5, 5 * 595 + 2, "R9 R3 three-modulus Q=5");

        // R10: empty 65 phase skipped, N=7*64
        setcfg(2'b01, 5, 0, 0, 0, 1);
        wait_pulses(2);
        measure(1, 448, "R10 no 65 phase");

        // R6: smallest cycle with wraps, N=128, Q=5, nf=4
        setcfg(2'b01, 0, 0, 0, 4, 0);
        wait_pulses(2);
        measure(5, 5 * 128 + 4, "R6 wrap in minimal cycle");

        // R7: change settings in the middle of the 65 phase
        setcfg(2'b01, 6, 5, 0, 1, 1);
        wait_pulses(2);
        while (mod_sel != 2'd1) begin @(negedge clk); #1; end
        setcfg(2'b01, 1, 1, 0, 1, 1);
        wait_pulses(12);

        // R8: mid-run reset with a nonzero accumulator
        setcfg(2'b10, 3, 0, 2, 7, 1);
        wait_pulses(3);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk); #1;
        chk(acc_out == 3'd0, "R8 acc after mid-run reset", int'(acc_out), 0);
        chk(mod_sel == 2'd2, "R8 restart skips empty 65 phase", int'(mod_sel), 2);
        wait_pulses(10);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule